// File: doc/BRIEF.md
# Serial Port Register Block

This block is the register front end of a simple serial port. A host reaches it through a word-indexed register port. The port has a write strobe, a read strobe and read data that is registered. Behind that port the block holds the control, baud and timing registers. It also holds a single-character receive holding buffer and the status and test views of the port. Transmit writes appear as a one-cycle byte strobe on the transmit side. Received characters and break events arrive on the receive side, which is throttled by a ready level.

No bit timing is generated here. The baud, one-millisecond and FIFO-control registers are storage that reads back what was written, so that driver software finds what it expects. One registered interrupt line is formed from status bits and their enables. It is recomputed every cycle from the register state.

Top module: `uart_regblock`

## Requirements
- R1: A hard reset leaves these values. Control 1 (index 0x20) is 0x0010, where bit 4 is port enable. Control 2 (0x21) is 0x0005, where bit 0 is the active-low soft-reset bit and bit 2 is transmit enable. Control 3 (0x22) is 0x0700, and control 4 (0x23), FIFO control (0x24), modulator (0x2A) and one-millisecond (0x2C) are 0. Baud count (0x2B) is 4. Status 1 (0x25) is 0x000D, status 2 (0x26) is 0x000E and the test view (0x2D) is 0x0003. Receive data (0x00) is 0x4000, irq is low and rx_ready is high.
- R2: Writes to control 1–4, FIFO control, modulator and one-millisecond keep only bits 15:0 of the write data, and those registers read back the kept value. A write to the baud-increment index 0x29 loads the baud count, which is read at 0x2B. A read of 0x29 returns 0.
- R3: Reads of unmapped indices return 0. Writes to unmapped indices, to the test view and to the receive data index change no readable state.
- R4: A receive delivery (rx_valid) is accepted only while rx_ready is high, and rx_ready is low exactly while the buffer is full. On acceptance, status 1 bit 1 (receive ready) and status 2 bit 0 (data ready) rise, and test bit 0 (receive empty) falls. A delivery while the buffer is full is dropped.
- R5: A read of receive data while the buffer is full returns the stored word with bit 15 (char ready) set, and it empties the buffer. A read while the buffer is empty returns the stored word with bit 15 clear. The stored character sits in bits 7:0.
- R6: A delivery with rx_break set stores the word 0x5400 (break bit 10, framing bit 12, error bit 14) and sets status 2 bit 8 (break detect).
- R7: A write to transmit data (0x10) while control 2 bit 2 is set drives tx_valid high for one cycle, with tx_data equal to write bits 7:0. The same write with that bit clear produces no strobe.
- R8: For the one cycle after a send, status 1 bit 0 (transmit ready) and status 2 bit 3 (transmit complete) read 0. After that they read 1 again.
- R9: Writes to status 1 or status 2 clear only those bits of 15:8 that are written as 1. Bits 7:0 ignore writes.
- R10: A write to control 2 with bit 0 equal to 0 does three things. It returns control 1, control 3, modulator, baud count, break detect, the receive buffer and the transmit state to their R1 values, with control 1 becoming 0. It stores control 2 as the written value with bit 0 forced to 1. It leaves control 4, FIFO control and one-millisecond unchanged.
- R11: irq is a register. One cycle after the state it reflects, it is high if any of four pairs are both set. Status 1 bit 0 pairs with control 1 bit 0, and status 1 bit 1 with control 1 bit 1. Status 2 bit 1 (transmit empty) pairs with control 1 bit 2. Status 2 bit 3 pairs with control 4 bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hard reset |
| reg_addr | input | ADDR_W | Register word index |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, valid the cycle after reg_rd |
| tx_valid | output | 1 | One-cycle transmit byte strobe |
| tx_data | output | CHAR_W | Transmit byte |
| rx_valid | input | 1 | Receive delivery strobe |
| rx_data | input | CHAR_W | Received character |
| rx_break | input | 1 | Delivery is a break event |
| rx_ready | output | 1 | Receive buffer can accept a delivery |
| irq | output | 1 | Level interrupt |

## Verification
The case hardest to reach from the ports is the one-cycle dip of transmit ready and transmit complete. It shows in status reads and in the interrupt only for the single cycle after a send. The bench reaches it by issuing a status read in the cycle right after the transmit write. It also follows irq cycle by cycle with the transmit-ready enable set, expecting high, low, then high. The second such case is a delivery dropped while the buffer is full. The bench forces it by presenting a second character before reading the first, then checking that the first is returned.

// File: rtl/uart_regblock_pkg.sv
package uart_regblock_pkg;
  // register word indices
  localparam logic [5:0] IX_RXD  = 6'h00;
  localparam logic [5:0] IX_TXD  = 6'h10;
  localparam logic [5:0] IX_CR1  = 6'h20;
  localparam logic [5:0] IX_CR2  = 6'h21;
  localparam logic [5:0] IX_CR3  = 6'h22;
  localparam logic [5:0] IX_CR4  = 6'h23;
  localparam logic [5:0] IX_FCR  = 6'h24;
  localparam logic [5:0] IX_SR1  = 6'h25;
  localparam logic [5:0] IX_SR2  = 6'h26;
  localparam logic [5:0] IX_BINC = 6'h29;
  localparam logic [5:0] IX_BMOD = 6'h2A;
  localparam logic [5:0] IX_BCNT = 6'h2B;
  localparam logic [5:0] IX_MS   = 6'h2C;
  localparam logic [5:0] IX_TST  = 6'h2D;

  // status 1 bits
  localparam int SR1_TXRDY = 0;
  localparam int SR1_RXRDY = 1;
  localparam int SR1_IDLE  = 2;
  localparam int SR1_RTS   = 3;
  // status 2 bits
  localparam int SR2_DRDY  = 0;
  localparam int SR2_TXFE  = 1;
  localparam int SR2_DCD   = 2;
  localparam int SR2_TXDN  = 3;
  localparam int SR2_BRK   = 8;
  // control bits
  localparam int CR1_TXFE_IE = 2;
  localparam int CR2_SRSTN   = 0;
  localparam int CR2_TXEN    = 2;
  // test view bits
  localparam int TST_RXE = 0;
  localparam int TST_TXE = 1;
  // receive word
  localparam int RXW_CHRDY = 15;

  localparam logic [15:0] W1C_MASK      = 16'hFF00;
  localparam logic [15:0] SR1_IRQ_MASK  = 16'h0003;
  localparam logic [15:0] SR2_IRQ_MASK  = 16'h0008;
  localparam logic [15:0] CR1_BOOT      = 16'h0010;
  localparam logic [15:0] CR2_BOOT      = 16'h0005;
  localparam logic [15:0] CR3_RST       = 16'h0700;
  localparam logic [15:0] BCNT_RST      = 16'h0004;
  localparam logic [15:0] RXW_RST       = 16'h4000;
  localparam logic [15:0] RXW_BRK       = 16'h5400;
endpackage

// File: rtl/uart_rx_hold.sv
module uart_rx_hold #(
  parameter int CHAR_W = 8,
  parameter int WORD_W = 16,
  parameter logic [WORD_W-1:0] RST_WORD = '0,
  parameter logic [WORD_W-1:0] BRK_WORD = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              in_valid,
  input  logic [CHAR_W-1:0] in_data,
  input  logic              in_break,
  input  logic              pop,
  output logic              full,
  output logic [WORD_W-1:0] word,
  output logic              brk_evt
);
  logic accept;
  assign accept  = in_valid & ~full;
  assign brk_evt = accept & in_break & ~clr;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      full <= 1'b0;
      word <= RST_WORD;
    end else if (accept) begin
      full <= 1'b1;
      word <= in_break ? BRK_WORD : WORD_W'(in_data);
    end else if (pop && full) begin
      full <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_tx_path.sv
module uart_tx_path #(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              send,
  input  logic [CHAR_W-1:0] byte_in,
  output logic              tx_valid,
  output logic [CHAR_W-1:0] tx_data
);
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      tx_valid <= 1'b0;
      tx_data  <= '0;
    end else begin
      tx_valid <= send;
      if (send) tx_data <= byte_in;
    end
  end
endmodule

// File: rtl/uart_irq_gen.sv
module uart_irq_gen #(
  parameter int REG_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [REG_W-1:0] sr1,
  input  logic [REG_W-1:0] sr2,
  input  logic [REG_W-1:0] cr1,
  input  logic [REG_W-1:0] cr4,
  output logic             irq
);
  import uart_regblock_pkg::*;
  logic hit_sr1, hit_txfe, hit_sr2;
  assign hit_sr1  = |(sr1 & cr1 & REG_W'(SR1_IRQ_MASK));
  assign hit_txfe = sr2[SR2_TXFE] & cr1[CR1_TXFE_IE];
  assign hit_sr2  = |(sr2 & cr4 & REG_W'(SR2_IRQ_MASK));

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= hit_sr1 | hit_txfe | hit_sr2;
  end
endmodule

// File: rtl/uart_regblock.sv
module uart_regblock
  import uart_regblock_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32,
  parameter int REG_W  = 16,
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              tx_valid,
  output logic [CHAR_W-1:0] tx_data,
  input  logic              rx_valid,
  input  logic [CHAR_W-1:0] rx_data,
  input  logic              rx_break,
  output logic              rx_ready,
  output logic              irq
);
  logic [REG_W-1:0] wlo;
  logic             unused_whi;
  assign wlo        = reg_wdata[REG_W-1:0];
  assign unused_whi = ^reg_wdata[DATA_W-1:REG_W];

  logic [REG_W-1:0] cr1, cr2, cr3, cr4, fcr, bmod, bcnt, ms;
  logic             brk_det;
  logic             rx_full, brk_evt;
  logic [REG_W-1:0] rx_word;
  logic [REG_W-1:0] sr1, sr2, tst;

  logic hit_cr2, soft_rst, send, pop, wr_sr2;
  assign hit_cr2  = reg_wr && (reg_addr == ADDR_W'(IX_CR2));
  assign soft_rst = hit_cr2 && !reg_wdata[CR2_SRSTN];
  assign send     = reg_wr && (reg_addr == ADDR_W'(IX_TXD)) && cr2[CR2_TXEN];
  assign pop      = reg_rd && (reg_addr == ADDR_W'(IX_RXD));
  assign wr_sr2   = reg_wr && (reg_addr == ADDR_W'(IX_SR2));

  uart_rx_hold #(
    .CHAR_W(CHAR_W), .WORD_W(REG_W),
    .RST_WORD(REG_W'(RXW_RST)), .BRK_WORD(REG_W'(RXW_BRK))
  ) u_rx (
    .clk(clk), .rst(rst), .clr(soft_rst),
    .in_valid(rx_valid), .in_data(rx_data), .in_break(rx_break),
    .pop(pop), .full(rx_full), .word(rx_word), .brk_evt(brk_evt)
  );

  uart_tx_path #(.CHAR_W(CHAR_W)) u_tx (
    .clk(clk), .rst(rst), .clr(soft_rst), .send(send),
    .byte_in(reg_wdata[CHAR_W-1:0]), .tx_valid(tx_valid), .tx_data(tx_data)
  );

  assign rx_ready = ~rx_full;

  // live status views; only break detect is stored
  always_comb begin
    sr1 = '0;
    sr1[SR1_TXRDY] = ~tx_valid;
    sr1[SR1_RXRDY] = rx_full;
    sr1[SR1_IDLE]  = 1'b1;
    sr1[SR1_RTS]   = 1'b1;
    sr2 = '0;
    sr2[SR2_DRDY]  = rx_full;
    sr2[SR2_TXFE]  = 1'b1;
    sr2[SR2_DCD]   = 1'b1;
    sr2[SR2_TXDN]  = ~tx_valid;
    sr2[SR2_BRK]   = brk_det;
    tst = '0;
    tst[TST_RXE]   = ~rx_full;
    tst[TST_TXE]   = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cr1 <= REG_W'(CR1_BOOT);  cr2 <= REG_W'(CR2_BOOT);
      cr3 <= REG_W'(CR3_RST);   cr4 <= '0;
      fcr <= '0;  bmod <= '0;  bcnt <= REG_W'(BCNT_RST);  ms <= '0;
      brk_det <= 1'b0;
    end else if (soft_rst) begin
      cr1  <= '0;
      cr2  <= wlo | (REG_W'(1) << CR2_SRSTN);
      cr3  <= REG_W'(CR3_RST);
      bmod <= '0;
      bcnt <= REG_W'(BCNT_RST);
      brk_det <= 1'b0;
    end else begin
      if (brk_evt)                              brk_det <= 1'b1;
      else if (wr_sr2 && wlo[SR2_BRK] && W1C_MASK[SR2_BRK]) brk_det <= 1'b0;
      if (reg_wr) begin
        case (reg_addr)
          ADDR_W'(IX_CR1):  cr1  <= wlo;
          ADDR_W'(IX_CR2):  cr2  <= wlo;
          ADDR_W'(IX_CR3):  cr3  <= wlo;
          ADDR_W'(IX_CR4):  cr4  <= wlo;
          ADDR_W'(IX_FCR):  fcr  <= wlo;
          ADDR_W'(IX_BINC): bcnt <= wlo;
          ADDR_W'(IX_BMOD): bmod <= wlo;
          ADDR_W'(IX_MS):   ms   <= wlo;
          default: ;
        endcase
      end
    end
  end

  logic [REG_W-1:0] rd_val;
  always_comb begin
    case (reg_addr)
      ADDR_W'(IX_RXD):  rd_val = rx_word | (REG_W'(rx_full) << RXW_CHRDY);
      ADDR_W'(IX_CR1):  rd_val = cr1;
      ADDR_W'(IX_CR2):  rd_val = cr2;
      ADDR_W'(IX_CR3):  rd_val = cr3;
      ADDR_W'(IX_CR4):  rd_val = cr4;
      ADDR_W'(IX_FCR):  rd_val = fcr;
      ADDR_W'(IX_SR1):  rd_val = sr1;
      ADDR_W'(IX_SR2):  rd_val = sr2;
      ADDR_W'(IX_BMOD): rd_val = bmod;
      ADDR_W'(IX_BCNT): rd_val = bcnt;
      ADDR_W'(IX_MS):   rd_val = ms;
      ADDR_W'(IX_TST):  rd_val = tst;
      default:          rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= DATA_W'(rd_val);
  end

  uart_irq_gen #(.REG_W(REG_W)) u_irq (
    .clk(clk), .rst(rst), .sr1(sr1), .sr2(sr2), .cr1(cr1), .cr4(cr4), .irq(irq)
  );
endmodule

// File: rtl/uart_regblock_chk.sv
module uart_regblock_chk
  import uart_regblock_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32,
  parameter int REG_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic              tx_valid,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic              irq,
  input logic [REG_W-1:0]  cr1,
  input logic [REG_W-1:0]  cr2,
  input logic [REG_W-1:0]  cr4,
  input logic [REG_W-1:0]  rx_word
);
  assert_tx_origin_R7: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> $past(reg_wr && reg_addr == ADDR_W'(IX_TXD)));

  assert_tx_gate_R7: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == ADDR_W'(IX_TXD) && !cr2[CR2_TXEN]) |=> !tx_valid);

  assert_soft_reset_R10: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == ADDR_W'(IX_CR2) && !reg_wdata[CR2_SRSTN])
      |=> (cr2[CR2_SRSTN] && cr1 == '0));

  assert_irq_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    (cr1[2:0] == 3'b000 && !cr4[SR2_TXDN]) |=> !irq);

  assert_rx_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && !rx_ready && !reg_wr) |=> $stable(rx_word));

  assert_rx_pop_R5: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr == ADDR_W'(IX_RXD) && !rx_ready) |=> rx_ready);
endmodule

bind uart_regblock uart_regblock_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_W(REG_W)
) u_chk (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .tx_valid(tx_valid),
  .rx_valid(rx_valid), .rx_ready(rx_ready), .irq(irq),
  .cr1(cr1), .cr2(cr2), .cr4(cr4), .rx_word(rx_word)
);

// File: tb/uart_regblock_test.sv
`timescale 1ns/1ps
module uart_regblock_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  reg_addr = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        tx_valid;
  logic [7:0]  tx_data;
  logic        rx_valid = 1'b0, rx_break = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        rx_ready, irq;

  int n_chk = 0, n_fail = 0, cyc = 0, tx_cnt = 0;
  logic [7:0] tx_last = '0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  uart_regblock uut (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_valid(tx_valid),
    .tx_data(tx_data), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_break(rx_break), .rx_ready(rx_ready), .irq(irq)
  );

  always @(negedge clk) if (!rst && tx_valid) begin
    tx_cnt++;
    tx_last = tx_data;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 50000 && !done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic rd_chk(input string req, input logic [5:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic rx_send(input logic [7:0] d, input logic b);
    rx_data = d; rx_break = b; rx_valid = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0; rx_break = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 irq", {31'b0, irq}, 32'h0);
    chk("R1 rx_ready", {31'b0, rx_ready}, 32'h1);
    chk("R1 tx_valid", {31'b0, tx_valid}, 32'h0);
    rd_chk("R1 cr1", 6'h20, 32'h0010);
    rd_chk("R1 cr2", 6'h21, 32'h0005);
    rd_chk("R1 cr3", 6'h22, 32'h0700);
    rd_chk("R1 cr4", 6'h23, 32'h0000);
    rd_chk("R1 fcr", 6'h24, 32'h0000);
    rd_chk("R1 sr1", 6'h25, 32'h000D);
    rd_chk("R1 sr2", 6'h26, 32'h000E);
    rd_chk("R1 bmod", 6'h2A, 32'h0000);
    rd_chk("R1 bcnt", 6'h2B, 32'h0004);
    rd_chk("R1 ms", 6'h2C, 32'h0000);
    rd_chk("R1 tst", 6'h2D, 32'h0003);
    rd_chk("R1 rxd", 6'h00, 32'h4000);
  endtask

  task automatic t_mask;
    wr(6'h22, 32'hFFFF_1234); rd_chk("R2 cr3 low16", 6'h22, 32'h1234);
    wr(6'h24, 32'hABCD_0F0F); rd_chk("R2 fcr low16", 6'h24, 32'h0F0F);
    wr(6'h2C, 32'h0001_03E8); rd_chk("R2 ms low16", 6'h2C, 32'h03E8);
    wr(6'h2A, 32'h1234_5678); rd_chk("R2 bmod low16", 6'h2A, 32'h5678);
    wr(6'h29, 32'h0000_0033);
    rd_chk("R2 binc reads zero", 6'h29, 32'h0);
    rd_chk("R2 bcnt loaded via binc", 6'h2B, 32'h0033);
    wr(6'h23, 32'h0000_0000); rd_chk("R2 cr4", 6'h23, 32'h0);
  endtask

  task automatic t_unmapped;
    rd_chk("R3 unmapped read", 6'h05, 32'h0);
    wr(6'h30, 32'hDEAD_BEEF);
    rd_chk("R3 unmapped after write", 6'h30, 32'h0);
    wr(6'h2D, 32'h0);
    rd_chk("R3 tst write ignored", 6'h2D, 32'h0003);
    wr(6'h00, 32'h00FF);
    rd_chk("R3 rxd write ignored", 6'h00, 32'h4000);
  endtask

  task automatic t_tx;
    wr(6'h10, 32'h0000_01A5);
    rd_chk("R8 sr1 txrdy dip", 6'h25, 32'h000C);
    chk("R7 tx count", tx_cnt, 1);
    chk("R7 tx byte", {24'b0, tx_last}, 32'hA5);
    rd_chk("R8 sr1 txrdy back", 6'h25, 32'h000D);
    wr(6'h10, 32'h0000_003C);
    rd_chk("R8 sr2 txdone dip", 6'h26, 32'h0006);
    rd_chk("R8 sr2 txdone back", 6'h26, 32'h000E);
    chk("R7 tx byte 2", {24'b0, tx_last}, 32'h3C);
    wr(6'h21, 32'h0000_0001);
    wr(6'h10, 32'h0000_0033);
    @(negedge clk); @(negedge clk);
    chk("R7 tx gated by enable", tx_cnt, 2);
    wr(6'h21, 32'h0000_0005);
  endtask

  task automatic t_rx;
    chk("R4 ready before", {31'b0, rx_ready}, 32'h1);
    rx_send(8'h5A, 1'b0);
    chk("R4 ready low when full", {31'b0, rx_ready}, 32'h0);
    rd_chk("R4 sr1 rxrdy", 6'h25, 32'h000F);
    rd_chk("R4 sr2 drdy", 6'h26, 32'h000F);
    rd_chk("R4 tst rx not empty", 6'h2D, 32'h0002);
    rx_send(8'h77, 1'b0);
    rd_chk("R5 read full buffer", 6'h00, 32'h805A);
    rd_chk("R5 read empty buffer", 6'h00, 32'h005A);
    rd_chk("R5 sr1 cleared", 6'h25, 32'h000D);
    rd_chk("R5 tst empty", 6'h2D, 32'h0003);
    chk("R5 ready again", {31'b0, rx_ready}, 32'h1);
  endtask

  task automatic t_break;
    rx_send(8'h00, 1'b1);
    rd_chk("R6 sr2 break", 6'h26, 32'h010F);
    rd_chk("R6 break word", 6'h00, 32'hD400);
    rd_chk("R6 sr2 after read", 6'h26, 32'h010E);
    wr(6'h26, 32'h0000_00FF);
    rd_chk("R9 low bits ignore w1c", 6'h26, 32'h010E);
    wr(6'h25, 32'hFFFF_FFFF);
    rd_chk("R9 sr1 fixed bits kept", 6'h25, 32'h000D);
    wr(6'h26, 32'h0000_0100);
    rd_chk("R9 break cleared", 6'h26, 32'h000E);
  endtask

  task automatic t_irq;
    chk("R11 irq idle", {31'b0, irq}, 32'h0);
    wr(6'h20, 32'h0011); @(negedge clk);
    chk("R11 irq txrdy", {31'b0, irq}, 32'h1);
    wr(6'h10, 32'h0041);
    chk("R11 irq before dip", {31'b0, irq}, 32'h1);
    @(negedge clk);
    chk("R8 irq dips with txrdy", {31'b0, irq}, 32'h0);
    @(negedge clk);
    chk("R8 irq restored", {31'b0, irq}, 32'h1);
    wr(6'h20, 32'h0010); @(negedge clk);
    chk("R11 irq off", {31'b0, irq}, 32'h0);
    wr(6'h20, 32'h0014); @(negedge clk);
    chk("R11 irq txfe", {31'b0, irq}, 32'h1);
    wr(6'h20, 32'h0010);
    wr(6'h23, 32'h0008); @(negedge clk);
    chk("R11 irq txdone via cr4", {31'b0, irq}, 32'h1);
    wr(6'h23, 32'h0000);
    wr(6'h20, 32'h0012); @(negedge clk);
    chk("R11 irq rx empty", {31'b0, irq}, 32'h0);
    rx_send(8'h11, 1'b0); @(negedge clk);
    chk("R11 irq rxrdy", {31'b0, irq}, 32'h1);
    rd_chk("R11 rx read", 6'h00, 32'h8011);
    @(negedge clk);
    chk("R11 irq cleared by read", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_soft;
    wr(6'h20, 32'h0013); wr(6'h22, 32'hABCD); wr(6'h23, 32'h0008);
    wr(6'h24, 32'h1234); wr(6'h2C, 32'h0055); wr(6'h2A, 32'h0077);
    wr(6'h29, 32'h0099);
    rx_send(8'h42, 1'b0);
    wr(6'h21, 32'h0000_0006);
    rd_chk("R10 cr2 srst forced", 6'h21, 32'h0007);
    rd_chk("R10 cr1", 6'h20, 32'h0000);
    rd_chk("R10 cr3", 6'h22, 32'h0700);
    rd_chk("R10 bmod", 6'h2A, 32'h0000);
    rd_chk("R10 bcnt", 6'h2B, 32'h0004);
    rd_chk("R10 rxd", 6'h00, 32'h4000);
    rd_chk("R10 sr1", 6'h25, 32'h000D);
    rd_chk("R10 sr2", 6'h26, 32'h000E);
    rd_chk("R10 tst", 6'h2D, 32'h0003);
    rd_chk("R10 cr4 kept", 6'h23, 32'h0008);
    rd_chk("R10 fcr kept", 6'h24, 32'h1234);
    rd_chk("R10 ms kept", 6'h2C, 32'h0055);
    chk("R10 rx_ready", {31'b0, rx_ready}, 32'h1);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset;
    t_mask;
    t_unmapped;
    t_tx;
    t_rx;
    t_break;
    t_irq;
    t_soft;
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule